// File: doc/BRIEF.md
# Divided-clock serial master

This block runs a synchronous serial transfer of a configurable number of bits from a system clock. A start strobe takes in a divider setting, a word length and a parallel transmit word. The block then drives an active-low select line and produces a serial clock whose period and pulse widths come from the divider. It presents transmit bits most significant first and gathers receive bits into a right-aligned parallel word. A one-cycle done pulse marks the end of the transfer.

The serial clock rests low. The first bit is already on the data line when the select falls, and the receiver samples on each falling edge. The data line has its own output-enable, so a pad or an external buffer can release the wire after the last bit. One system clock cycle is the base tick of all timing below. With divider value D, the serial clock period is 2·(1+D) cycles.

Top module: `spi_div_master`

## Requirements
- R1: The serial clock period is 2·(1+D) system cycles. The serial clock is low whenever the select is high.
- R2: For D = 0 the high and low phases are one cycle each. For odd D they are D+1 cycles each.
- R3: For even D ≥ 2 the low phase is D cycles and the high phase is D+2 cycles.
- R4: The select goes low in the cycle after a start is taken. The first rising edge comes one low-phase time later. After the last falling edge the select stays low for one more low-phase time and then goes high.
- R5: From the cycle the select falls, the data line carries bit N-1 of the transmit word. At each rising edge except the last, it advances one bit lower, down to bit 0.
- R6: The output-enable is high from the select's falling cycle until the N-th rising edge. At that edge it goes low and stays low through idle.
- R7: The receive input is sampled at each falling edge of the serial clock. The N samples form the receive word in arrival order, right-aligned, with zeros above bit N-1. The receive word changes only in the done cycle.
- R8: Done is high for exactly one cycle, in the cycle after the select returns high.
- R9: A start is ignored while a transfer is running, including the cycle in which the select is high before done. A start in the done cycle is taken.
- R10: The word length N is the length input clamped to 4..WMAX (32 by default). A value below 4 acts as 4, and a value above WMAX acts as WMAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a transfer when idle |
| div_val | input | DIVW | Clock divider value D |
| word_len | input | LENW | Requested bits per transfer |
| tx_word | input | WMAX | Parallel transmit data, right-aligned |
| miso | input | 1 | Serial receive data |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low select |
| mosi | output | 1 | Serial transmit data |
| mosi_oe | output | 1 | Drive enable for the transmit line |
| rx_word | output | WMAX | Received word, right-aligned |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The done pulse and the acceptance of a new start can fall in the same cycle. The bench provokes this by raising start in the cycle where done is seen, and it also raises start one cycle earlier, while the select is already high. The behavioural model accepts the first and ignores the second. The select, clock, data and enable are compared with the model on every cycle, so a start that is wrongly taken or wrongly dropped shows up as a timing mismatch on the following frame.

// File: rtl/spim_pkg.sv
package spim_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_HIGH,
      ST_LOW,
      ST_FIN
   } spim_state_t;
endpackage

// File: rtl/spim_div.sv
// Converts the divider value into phase lengths minus one (in system cycles).
module spim_div #(
   parameter int DIVW = 8,
   parameter int CW   = DIVW + 1
) (
   input  logic [DIVW-1:0] div,
   output logic [CW-1:0]   hi_m1,
   output logic [CW-1:0]   lo_m1
);
   logic [CW-1:0] d_ext;

   always_comb begin
      d_ext = {1'b0, div};
      if (div == '0) begin
         hi_m1 = '0;
         lo_m1 = '0;
      end else if (div[0]) begin
         hi_m1 = d_ext;
         lo_m1 = d_ext;
      end else begin
         hi_m1 = d_ext + 1'b1;
         lo_m1 = d_ext - 1'b1;
      end
   end
endmodule

// File: rtl/spim_ctrl.sv
// Phase sequencer: select, serial clock, bit count and strobes for the shifter.
module spim_ctrl
   import spim_pkg::*;
#(
   parameter int DIVW = 8,
   parameter int WMAX = 32,
   parameter int WMIN = 4,
   parameter int LENW = $clog2(WMAX + 1),
   parameter int CW   = DIVW + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [LENW-1:0] len_in,
   input  logic [DIVW-1:0] div_in,
   output logic            sclk,
   output logic            cs_n,
   output logic            done,
   output logic            load,
   output logic            tx_shift,
   output logic            oe_off,
   output logic            rx_take,
   output logic            fin,
   output logic [LENW-1:0] n_new
);
   spim_state_t     st;
   logic [CW-1:0]   cnt;
   logic [LENW-1:0] bitn;
   logic [LENW-1:0] bit_nx;
   logic [LENW-1:0] n_q;
   logic [DIVW-1:0] div_q;
   logic [DIVW-1:0] div_sel;
   logic [CW-1:0]   hi_m1;
   logic [CW-1:0]   lo_m1;
   logic            rise;

   assign div_sel = (st == ST_IDLE) ? div_in : div_q;

   spim_div #(.DIVW(DIVW), .CW(CW)) u_div (
      .div   (div_sel),
      .hi_m1 (hi_m1),
      .lo_m1 (lo_m1)
   );

   always_comb begin
      if (len_in < LENW'(WMIN))      n_new = LENW'(WMIN);
      else if (len_in > LENW'(WMAX)) n_new = LENW'(WMAX);
      else                           n_new = len_in;
   end

   assign bit_nx   = bitn + 1'b1;
   assign load     = (st == ST_IDLE) && start;
   assign rise     = (cnt == '0) &&
                     ((st == ST_LEAD) || ((st == ST_LOW) && (bitn != n_q)));
   assign tx_shift = rise && (bit_nx != n_q);
   assign oe_off   = rise && (bit_nx == n_q);
   assign rx_take  = (st == ST_HIGH) && (cnt == '0);
   assign fin      = (st == ST_FIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         cnt   <= '0;
         bitn  <= '0;
         n_q   <= LENW'(WMIN);
         div_q <= '0;
         sclk  <= 1'b0;
         cs_n  <= 1'b1;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start) begin
                  st    <= ST_LEAD;
                  cs_n  <= 1'b0;
                  cnt   <= lo_m1;
                  bitn  <= '0;
                  n_q   <= n_new;
                  div_q <= div_in;
               end
            end
            ST_LEAD: begin
               if (cnt == '0) begin
                  st   <= ST_HIGH;
                  sclk <= 1'b1;
                  cnt  <= hi_m1;
                  bitn <= bit_nx;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_HIGH: begin
               if (cnt == '0) begin
                  st   <= ST_LOW;
                  sclk <= 1'b0;
                  cnt  <= lo_m1;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_LOW: begin
               if (cnt == '0) begin
                  if (bitn == n_q) begin
                     st   <= ST_FIN;
                     cs_n <= 1'b1;
                  end else begin
                     st   <= ST_HIGH;
                     sclk <= 1'b1;
                     cnt  <= hi_m1;
                     bitn <= bit_nx;
                  end
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_FIN: begin
               st   <= ST_IDLE;
               done <= 1'b1;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/spim_shift.sv
// Transmit and receive shift registers with the line enable.
module spim_shift #(
   parameter int WMAX = 32,
   parameter int LENW = $clog2(WMAX + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [LENW-1:0] n_new,
   input  logic [WMAX-1:0] tx_in,
   input  logic            tx_shift,
   input  logic            oe_off,
   input  logic            rx_take,
   input  logic            fin,
   input  logic            miso,
   output logic            mosi,
   output logic            mosi_oe,
   output logic [WMAX-1:0] rx_word
);
   logic [WMAX-1:0] tx_sh;
   logic [WMAX-1:0] rx_sh;
   logic [LENW-1:0] shamt;

   assign shamt = LENW'(WMAX) - n_new;
   assign mosi  = tx_sh[WMAX-1] & mosi_oe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh   <= '0;
         rx_sh   <= '0;
         mosi_oe <= 1'b0;
         rx_word <= '0;
      end else begin
         if (load) begin
            tx_sh   <= tx_in << shamt;
            rx_sh   <= '0;
            mosi_oe <= 1'b1;
         end else begin
            if (tx_shift) tx_sh   <= tx_sh << 1;
            if (oe_off)   mosi_oe <= 1'b0;
            if (rx_take)  rx_sh   <= {rx_sh[WMAX-2:0], miso};
            if (fin)      rx_word <= rx_sh;
         end
      end
   end
endmodule

// File: rtl/spi_div_master.sv
module spi_div_master #(
   parameter int DIVW = 8,
   parameter int WMAX = 32,
   parameter int WMIN = 4,
   parameter int LENW = $clog2(WMAX + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [DIVW-1:0] div_val,
   input  logic [LENW-1:0] word_len,
   input  logic [WMAX-1:0] tx_word,
   input  logic            miso,
   output logic            sclk,
   output logic            cs_n,
   output logic            mosi,
   output logic            mosi_oe,
   output logic [WMAX-1:0] rx_word,
   output logic            done
);
   localparam int CW = DIVW + 1;

   if (WMIN < 2 || WMAX < WMIN) begin : g_bad_len
      initial $error("spi_div_master: word length bounds invalid");
   end
   if (DIVW < 1) begin : g_bad_div
      initial $error("spi_div_master: divider width must be at least 1");
   end

   logic            load;
   logic            tx_shift;
   logic            oe_off;
   logic            rx_take;
   logic            fin;
   logic [LENW-1:0] n_new;

   spim_ctrl #(
      .DIVW(DIVW), .WMAX(WMAX), .WMIN(WMIN), .LENW(LENW), .CW(CW)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .len_in   (word_len),
      .div_in   (div_val),
      .sclk     (sclk),
      .cs_n     (cs_n),
      .done     (done),
      .load     (load),
      .tx_shift (tx_shift),
      .oe_off   (oe_off),
      .rx_take  (rx_take),
      .fin      (fin),
      .n_new    (n_new)
   );

   spim_shift #(.WMAX(WMAX), .LENW(LENW)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .n_new    (n_new),
      .tx_in    (tx_word),
      .tx_shift (tx_shift),
      .oe_off   (oe_off),
      .rx_take  (rx_take),
      .fin      (fin),
      .miso     (miso),
      .mosi     (mosi),
      .mosi_oe  (mosi_oe),
      .rx_word  (rx_word)
   );
endmodule

// File: rtl/spi_div_master_chk.sv
module spi_div_master_chk #(
   parameter int WMAX = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            sclk,
   input logic            cs_n,
   input logic            mosi,
   input logic            mosi_oe,
   input logic [WMAX-1:0] rx_word,
   input logic            done
);
   a_r1_sclk_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   a_r5_mosi_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(mosi));

   a_r6_oe_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      mosi_oe |-> !cs_n);

   a_r6_oe_drop_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mosi_oe) |-> $rose(sclk));

   a_r7_rx_only_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_word) |-> done);

   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r8_done_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |=> done);
endmodule

bind spi_div_master spi_div_master_chk #(.WMAX(WMAX)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .sclk    (sclk),
   .cs_n    (cs_n),
   .mosi    (mosi),
   .mosi_oe (mosi_oe),
   .rx_word (rx_word),
   .done    (done)
);

// File: tb/sim_spi_div_master.sv
`timescale 1ns/1ps
module sim_spi_div_master;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  div_val = '0;
   logic [5:0]  word_len = 6'd8;
   logic [31:0] tx_word = '0;
   logic        miso = 1'b0;
   logic        sclk, cs_n, mosi, mosi_oe, done;
   logic [31:0] rx_word;

   int total = 0;
   int bad = 0;
   bit ended = 0;

   always #5 clk = ~clk;

   spi_div_master u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .div_val(div_val),
      .word_len(word_len), .tx_word(tx_word), .miso(miso), .sclk(sclk),
      .cs_n(cs_n), .mosi(mosi), .mosi_oe(mosi_oe), .rx_word(rx_word),
      .done(done)
   );

   task automatic chk(input bit ok, input string what, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
      end
   endtask

   function automatic int clampn(input int l);
      if (l < 4) return 4;
      if (l > 32) return 32;
      return l;
   endfunction

   // Behavioural reference model: time since acceptance and derived phases.
   bit          m_act = 0;
   int          m_t, m_n, m_h, m_l, m_tot;
   logic [31:0] m_tx, m_sw;
   logic [31:0] slave_w = '0;
   int          slave_n = 8;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_act = 0;
      end else if ((!m_act || m_t == m_tot + 1) && start) begin
         int d;
         d     = int'(div_val);
         m_act = 1;
         m_t   = 0;
         m_n   = clampn(int'(word_len));
         if (d == 0)          begin m_h = 1;     m_l = 1;     end
         else if (d % 2 == 1) begin m_h = d + 1; m_l = d + 1; end
         else                 begin m_h = d + 2; m_l = d;     end
         m_tot = m_l + m_n * (m_h + m_l);
         m_tx  = tx_word;
         m_sw  = slave_w;
      end else if (m_act) begin
         if (m_t == m_tot + 1) m_act = 0;
         else m_t++;
      end
   end

   // Per-cycle comparison and slave emulation, away from the active edge.
   int r_cnt = 0;
   bit prev_sclk = 0;
   always @(negedge clk) begin
      if (rst_n && !ended) begin
         bit e_cs, e_sclk, e_oe, e_done;
         int k;
         longint mask;
         e_cs   = !(m_act && m_t < m_tot);
         e_sclk = m_act && m_t >= m_l && m_t < m_tot - m_l &&
                  ((m_t - m_l) % (m_h + m_l)) < m_h;
         e_oe   = m_act && m_t < m_l + (m_n - 1) * (m_h + m_l);
         e_done = m_act && m_t == m_tot + 1;
         chk(cs_n == e_cs, "R4 select timing", cs_n, e_cs);
         chk(sclk == e_sclk, "R1 R2 R3 serial clock shape", sclk, e_sclk);
         chk(mosi_oe == e_oe, "R6 output enable", mosi_oe, e_oe);
         chk(done == e_done, "R8 done pulse", done, e_done);
         if (e_oe) begin
            k = (m_t < m_l) ? 0 : ((m_t - m_l) / (m_h + m_l)) + 1;
            chk(mosi == m_tx[m_n - 1 - k], "R5 data bit order", mosi, m_tx[m_n - 1 - k]);
         end
         if (e_done) begin
            mask = (longint'(1) << m_n) - 1;
            chk(longint'(rx_word) == (longint'(m_sw) & mask), "R7 received word",
                rx_word, longint'(m_sw) & mask);
         end
      end
      if (cs_n) r_cnt = 0;
      else if (sclk && !prev_sclk) r_cnt++;
      prev_sclk = sclk;
      miso <= (r_cnt >= 1 && r_cnt <= slave_n) ? slave_w[slave_n - r_cnt] : 1'b0;
   end

   task automatic kick(input int d, input int l, input logic [31:0] tx, input logic [31:0] sw);
      @(negedge clk);
      div_val  = 8'(d);
      word_len = 6'(l);
      tx_word  = tx;
      slave_w  = sw;
      slave_n  = clampn(l);
      start    = 1'b1;
      @(negedge clk);
      start    = 1'b0;
   endtask

   task automatic wait_done();
      do @(negedge clk); while (!done);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic report();
      if (!ended) begin
         ended = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(cs_n == 1'b1, "R4 reset select high", cs_n, 1);
      chk(sclk == 1'b0, "R1 reset clock low", sclk, 0);
      chk(mosi_oe == 1'b0, "R6 reset enable low", mosi_oe, 0);
      chk(done == 1'b0, "R8 reset done low", done, 0);
      chk(rx_word == 32'h0, "R7 reset receive word", rx_word, 0);
      rst_n = 1'b1;
      idle(3);

      kick(0, 8, 32'hA5, 32'h3C);                       wait_done(); idle(3); // R2 D=0
      kick(1, 4, 32'h9, 32'h6);                         wait_done(); idle(3); // R2 odd
      kick(2, 32, 32'hDEADBEEF, 32'h1234ABCD);          wait_done(); idle(3); // R3 even
      kick(3, 13, 32'h1ACE, 32'h0F0F);                  wait_done(); idle(3); // R2 odd
      kick(4, 5, 32'h15, 32'h0A);                       wait_done(); idle(3); // R3 even
      kick(0, 2, 32'hFFFF_FFF3, 32'hB);                 wait_done(); idle(3); // R10 low clamp
      kick(1, 45, 32'h8000_0001, 32'hC001_D00D);        wait_done(); idle(3); // R10 high clamp
      chk(rx_word == 32'hC001_D00D, "R10 clamped to 32 bits", rx_word, 32'hC001_D00D);

      // R9: start pulses during the frame and in the select-high cycle are ignored.
      kick(2, 6, 32'h2D, 32'h33);
      idle(4);
      div_val = 8'd0; word_len = 6'd4; tx_word = 32'h5; start = 1'b1;
      @(negedge clk); start = 1'b0;
      do @(negedge clk); while (!cs_n);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(done == 1'b1, "R9 done after ignored start", done, 1);
      idle(2);
      chk(cs_n == 1'b1, "R9 no frame from ignored start", cs_n, 1);
      idle(3);

      // R9: start taken in the done cycle, back to back.
      kick(1, 7, 32'h55, 32'h2A);
      wait_done();
      div_val = 8'd2; word_len = 6'd9; tx_word = 32'h1F3; slave_w = 32'h0C5; slave_n = 9;
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(cs_n == 1'b0, "R9 start in done cycle accepted", cs_n, 0);
      wait_done(); idle(4);
      report();
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired (R8 done never seen) actual=0 expected=1");
      report();
   end
endmodule